// File: doc/BRIEF.md
# Paired-Word Instruction Fetch Buffer

This block supplies instructions to the decoder of a machine with 36-bit words. Its memory answers every access with a 72-bit pair: the word at an even address together with the word at the odd address just above it. The block keeps a 15-bit instruction counter. Each fetch reads the pair that holds the counter's word.

A fetch at an even address hands the even word to the decoder. It also keeps the odd word in a 36-bit backup register, tagged with the pair address. When the decoder accepts that even instruction, the counter moves to the odd address and the tag matches. The odd instruction then comes from the backup register on the next cycle, and memory is not used.

A branch loads the counter with a new target. It empties the backup register and cancels the instruction on offer. It also discards any memory response still in flight. A branch to an odd target fetches the pair and uses only its odd half, and the backup register stays empty.

Top module: `pair_fetch_buf`

## Requirements
- R1: After reset the counter holds RESET_PC (default 0), no instruction is offered (`ins_valid` low), the backup register is empty, and the first memory request names pair RESET_PC>>1.
- R2: A memory request is held with a stable `mem_req_addr` until `mem_req_ready` is seen. At most one request is outstanding, no request is raised while an instruction is offered, and `mem_req_addr` is the counter with its lowest bit dropped.
- R3: A response carries the even word in bits 71:36 and the odd word in bits 35:0. For an even counter the even word is delivered, and the odd word is stored in the backup register with the pair address as its tag.
- R4: When an even instruction is accepted and no branch arrives in that cycle, the odd instruction is offered in the very next cycle, taken from the backup register, with no memory request in between.
- R5: An offered instruction keeps `ins_word` and `ins_pc` stable until it is accepted (`ins_valid` and `ins_ready` both high). Each acceptance advances the counter by exactly 1.
- R6: A branch (`redirect_valid` high for a cycle) loads `redirect_pc` into the counter and empties the backup register. A stale backup word is never used, even when its tag matches the target. The response to a request issued before the branch is dropped.
- R7: A branch to an odd target fetches that pair and delivers only the odd word. The backup register stays empty, so the following even address is fetched from memory.
- R8: The counter wraps modulo 2^15: after address 7FFF (hex) the next instruction is at address 0, fetched from pair 0.
- R9: A branch in the same cycle as an acceptance wins. That acceptance does not count, and the next instruction delivered is the one at the target.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| redirect_valid | input | 1 | Branch: load the counter from redirect_pc |
| redirect_pc | input | 15 | Branch target word address |
| mem_req_valid | output | 1 | Pair fetch request |
| mem_req_ready | input | 1 | Memory takes the request |
| mem_req_addr | output | 14 | Pair address (word address without its lowest bit) |
| mem_rsp_valid | input | 1 | Response pulse for the outstanding request |
| mem_rsp_data | input | 72 | Even word in 71:36, odd word in 35:0 |
| ins_valid | output | 1 | Instruction offered to the decoder |
| ins_ready | input | 1 | Decoder accepts the offered instruction |
| ins_word | output | 36 | Offered instruction |
| ins_pc | output | 15 | Counter value, the address of the offered instruction |

## Verification
The properties assume the following about the environment. Memory returns exactly one single-cycle response for each accepted request, and only while that request is outstanding. A branch is a single-cycle pulse, and it may land in any state, including the cycle of a request handshake or an instruction acceptance. The bench's memory model answers requests in order, after a random delay of zero to two cycles, and only ever has one answer pending. Ready signals and branches are random. Directed branches aim at the odd partner of a word just delivered, at odd targets, and at the top of the address space.

// File: rtl/pfb_pkg.sv
package pfb_pkg;
    typedef enum logic [1:0] {
        FS_REQ  = 2'd0,
        FS_WAIT = 2'd1,
        FS_OUT  = 2'd2
    } fetch_state_e;
endpackage

// File: rtl/pfb_counter.sv
module pfb_counter #(
    parameter int               ADDR_W   = 15,
    parameter logic [ADDR_W-1:0] RESET_PC = '0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [ADDR_W-1:0] load_pc,
    input  logic              step,
    output logic [ADDR_W-1:0] pc,
    output logic [ADDR_W-1:0] pc_inc
);
    localparam logic [ADDR_W-1:0] ONE = {{(ADDR_W-1){1'b0}}, 1'b1};

    typedef struct packed {
        logic [ADDR_W-1:0] pc;
    } ctr_t;

    ctr_t ctr_d, ctr_q;

    always_comb begin
        ctr_d  = ctr_q;
        pc_inc = ctr_q.pc + ONE;
        if (load) begin
            ctr_d.pc = load_pc;
        end else if (step) begin
            ctr_d.pc = pc_inc;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctr_q.pc <= RESET_PC;
        end else begin
            ctr_q <= ctr_d;
        end
    end

    assign pc = ctr_q.pc;
endmodule

// File: rtl/pfb_backup.sv
module pfb_backup #(
    parameter int ADDR_W = 15,
    parameter int WORD_W = 36,
    localparam int TAG_W = ADDR_W - 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear,
    input  logic              fill,
    input  logic [TAG_W-1:0]  fill_tag,
    input  logic [WORD_W-1:0] fill_word,
    input  logic [ADDR_W-1:0] lookup_pc,
    output logic              hit,
    output logic [WORD_W-1:0] word
);
    typedef struct packed {
        logic              valid;
        logic [TAG_W-1:0]  tag;
        logic [WORD_W-1:0] word;
    } bkp_t;

    bkp_t bkp_d, bkp_q;

    always_comb begin
        bkp_d = bkp_q;
        if (clear) begin
            bkp_d.valid = 1'b0;
        end else if (fill) begin
            bkp_d.valid = 1'b1;
            bkp_d.tag   = fill_tag;
            bkp_d.word  = fill_word;
        end
        hit  = bkp_q.valid && lookup_pc[0] && (bkp_q.tag == lookup_pc[ADDR_W-1:1]);
        word = bkp_q.word;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bkp_q.valid <= 1'b0;
            bkp_q.tag   <= '0;
            bkp_q.word  <= '0;
        end else begin
            bkp_q <= bkp_d;
        end
    end
endmodule

// File: rtl/pfb_ctrl.sv
module pfb_ctrl
    import pfb_pkg::*;
#(
    parameter int WORD_W = 36,
    localparam int PAIR_W = 2 * WORD_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              redirect,
    input  logic              pc_odd,
    input  logic              req_ready,
    input  logic              rsp_valid,
    input  logic [PAIR_W-1:0] rsp_data,
    input  logic              ins_ready,
    input  logic              buf_hit,
    input  logic [WORD_W-1:0] buf_word,
    output logic              req_valid,
    output logic              ins_valid,
    output logic [WORD_W-1:0] ins_word,
    output logic              step,
    output logic              fill,
    output logic [WORD_W-1:0] fill_word
);
    typedef struct packed {
        fetch_state_e      state;
        logic              drop;
        logic [WORD_W-1:0] out_word;
    } ctl_t;

    ctl_t ctl_d, ctl_q;
    logic [WORD_W-1:0] even_w, odd_w;

    always_comb begin
        ctl_d     = ctl_q;
        step      = 1'b0;
        fill      = 1'b0;
        even_w    = rsp_data[PAIR_W-1:WORD_W];
        odd_w     = rsp_data[WORD_W-1:0];
        fill_word = odd_w;
        req_valid = (ctl_q.state == FS_REQ);
        ins_valid = (ctl_q.state == FS_OUT);
        ins_word  = ctl_q.out_word;

        if (redirect) begin
            unique case (ctl_q.state)
                FS_REQ: begin
                    if (req_ready) begin
                        ctl_d.state = FS_WAIT;
                        ctl_d.drop  = 1'b1;
                    end
                end
                FS_WAIT: begin
                    if (rsp_valid) begin
                        ctl_d.state = FS_REQ;
                        ctl_d.drop  = 1'b0;
                    end else begin
                        ctl_d.drop  = 1'b1;
                    end
                end
                default: begin
                    ctl_d.state = FS_REQ;
                end
            endcase
        end else begin
            unique case (ctl_q.state)
                FS_REQ: begin
                    if (req_ready) begin
                        ctl_d.state = FS_WAIT;
                    end
                end
                FS_WAIT: begin
                    if (rsp_valid) begin
                        if (ctl_q.drop) begin
                            ctl_d.drop  = 1'b0;
                            ctl_d.state = FS_REQ;
                        end else begin
                            ctl_d.out_word = pc_odd ? odd_w : even_w;
                            fill           = !pc_odd;
                            ctl_d.state    = FS_OUT;
                        end
                    end
                end
                default: begin
                    if (ins_ready) begin
                        step = 1'b1;
                        if (buf_hit) begin
                            ctl_d.out_word = buf_word;
                            ctl_d.state    = FS_OUT;
                        end else begin
                            ctl_d.state    = FS_REQ;
                        end
                    end
                end
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctl_q.state    <= FS_REQ;
            ctl_q.drop     <= 1'b0;
            ctl_q.out_word <= '0;
        end else begin
            ctl_q <= ctl_d;
        end
    end
endmodule

// File: rtl/pair_fetch_buf.sv
module pair_fetch_buf #(
    parameter int                ADDR_W   = 15,
    parameter int                WORD_W   = 36,
    parameter logic [ADDR_W-1:0] RESET_PC = '0,
    localparam int PAIR_AW = ADDR_W - 1,
    localparam int PAIR_W  = 2 * WORD_W
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               redirect_valid,
    input  logic [ADDR_W-1:0]  redirect_pc,
    output logic               mem_req_valid,
    input  logic               mem_req_ready,
    output logic [PAIR_AW-1:0] mem_req_addr,
    input  logic               mem_rsp_valid,
    input  logic [PAIR_W-1:0]  mem_rsp_data,
    output logic               ins_valid,
    input  logic               ins_ready,
    output logic [WORD_W-1:0]  ins_word,
    output logic [ADDR_W-1:0]  ins_pc
);
    logic [ADDR_W-1:0] pc, pc_inc;
    logic              step, fill, buf_hit;
    logic [WORD_W-1:0] buf_word, fill_word;

    pfb_counter #(.ADDR_W(ADDR_W), .RESET_PC(RESET_PC)) u_counter (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (redirect_valid),
        .load_pc (redirect_pc),
        .step    (step),
        .pc      (pc),
        .pc_inc  (pc_inc)
    );

    pfb_backup #(.ADDR_W(ADDR_W), .WORD_W(WORD_W)) u_backup (
        .clk       (clk),
        .rst_n     (rst_n),
        .clear     (redirect_valid),
        .fill      (fill),
        .fill_tag  (pc[ADDR_W-1:1]),
        .fill_word (fill_word),
        .lookup_pc (pc_inc),
        .hit       (buf_hit),
        .word      (buf_word)
    );

    pfb_ctrl #(.WORD_W(WORD_W)) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .redirect  (redirect_valid),
        .pc_odd    (pc[0]),
        .req_ready (mem_req_ready),
        .rsp_valid (mem_rsp_valid),
        .rsp_data  (mem_rsp_data),
        .ins_ready (ins_ready),
        .buf_hit   (buf_hit),
        .buf_word  (buf_word),
        .req_valid (mem_req_valid),
        .ins_valid (ins_valid),
        .ins_word  (ins_word),
        .step      (step),
        .fill      (fill),
        .fill_word (fill_word)
    );

    assign mem_req_addr = pc[ADDR_W-1:1];
    assign ins_pc       = pc;
endmodule

// File: rtl/pfb_checker.sv
module pfb_checker #(
    parameter int ADDR_W = 15,
    parameter int WORD_W = 36,
    localparam int PAIR_AW = ADDR_W - 1
) (
    input logic               clk,
    input logic               rst_n,
    input logic               redirect_valid,
    input logic [ADDR_W-1:0]  redirect_pc,
    input logic               mem_req_valid,
    input logic               mem_req_ready,
    input logic [PAIR_AW-1:0] mem_req_addr,
    input logic               ins_valid,
    input logic               ins_ready,
    input logic [WORD_W-1:0]  ins_word,
    input logic [ADDR_W-1:0]  ins_pc
);
    logic [ADDR_W-1:0] pc_plus;
    assign pc_plus = ins_pc + 1'b1;

    p_req_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_valid && !mem_req_ready && !redirect_valid |=> mem_req_valid && $stable(mem_req_addr));

    p_single_path_r2: assert property (@(posedge clk) disable iff (!rst_n)
        ins_valid |-> !mem_req_valid);

    p_ins_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        ins_valid && !ins_ready && !redirect_valid |=> ins_valid && $stable(ins_word) && $stable(ins_pc));

    p_pc_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
        ins_valid && ins_ready && !redirect_valid |=> ins_pc == $past(pc_plus));

    p_redirect_load_r6: assert property (@(posedge clk) disable iff (!rst_n)
        redirect_valid |=> ins_pc == $past(redirect_pc) && !ins_valid);

    p_buffer_next_r4: assert property (@(posedge clk) disable iff (!rst_n)
        ins_valid && ins_ready && !redirect_valid && !ins_pc[0] |=> ins_valid && !mem_req_valid);
endmodule

bind pair_fetch_buf pfb_checker #(.ADDR_W(ADDR_W), .WORD_W(WORD_W)) u_pfb_checker (
    .clk            (clk),
    .rst_n          (rst_n),
    .redirect_valid (redirect_valid),
    .redirect_pc    (redirect_pc),
    .mem_req_valid  (mem_req_valid),
    .mem_req_ready  (mem_req_ready),
    .mem_req_addr   (mem_req_addr),
    .ins_valid      (ins_valid),
    .ins_ready      (ins_ready),
    .ins_word       (ins_word),
    .ins_pc         (ins_pc)
);

// File: tb/test_pair_fetch_buf.sv
`timescale 1ns/1ps
module test_pair_fetch_buf;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        redirect_valid = 1'b0;
    logic [14:0] redirect_pc = '0;
    logic        mem_req_valid;
    logic        mem_req_ready = 1'b0;
    logic [13:0] mem_req_addr;
    logic        mem_rsp_valid = 1'b0;
    logic [71:0] mem_rsp_data = '0;
    logic        ins_valid;
    logic        ins_ready = 1'b0;
    logic [35:0] ins_word;
    logic [14:0] ins_pc;

    always #5 clk = ~clk;

    pair_fetch_buf i_pair_fetch_buf (
        .clk(clk), .rst_n(rst_n),
        .redirect_valid(redirect_valid), .redirect_pc(redirect_pc),
        .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready), .mem_req_addr(mem_req_addr),
        .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data),
        .ins_valid(ins_valid), .ins_ready(ins_ready), .ins_word(ins_word), .ins_pc(ins_pc)
    );

    int n_cmp = 0;
    int n_bad = 0;

    function automatic logic [35:0] word_at(logic [14:0] a);
        return {a, 6'h2A, ~a};
    endfunction

    task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
        end
    endtask

    logic [14:0] model_pc = '0;
    logic [13:0] pend_q[$];
    int          lat = 0;
    int          reqs_since = 0;
    bit          prev_even_fire = 0;
    logic [14:0] prev_even_pc = '0;
    bit          prev_hold = 0;
    logic [35:0] hold_word = '0;
    logic [14:0] hold_pc = '0;
    bit          first_req = 1;
    bit          armed = 0;
    bit          after_collide = 0;
    bit          after_wrap = 0;
    bit          redir_pending_chk = 0;
    int          idle_cycles = 0;

    initial begin
        // R1: reset state
        for (int i = 0; i < 4; i++) begin
            @(negedge clk);
            check(ins_valid == 1'b0, "R1 no instruction in reset", ins_valid, 0);
        end
        rst_n = 1'b1;
        for (int cyc = 0; cyc < 20000; cyc++) begin
            bit fire_ins, redir, fire_req;
            @(negedge clk);
            // drive inputs for the coming edge
            mem_req_ready = ($urandom % 3) != 0;
            ins_ready     = ($urandom % 4) != 0;
            redir = 0;
            if (cyc == 60) begin
                redir = 1; redirect_pc = 15'h7FFD;
            end else if (cyc == 400) begin
                redir = 1; redirect_pc = 15'h0011;
            end else if (armed && prev_even_fire) begin
                redir = 1; redirect_pc = prev_even_pc + 15'd1; armed = 0;
            end else if (cyc > 100 && ($urandom % 64) == 0) begin
                redir = 1;
                case ($urandom % 4)
                    0: redirect_pc = 15'h7FFE;
                    1: redirect_pc = 15'h7FFF;
                    default: redirect_pc = 15'($urandom);
                endcase
            end
            if (cyc % 700 == 350) armed = 1;
            redirect_valid = redir;
            mem_rsp_valid = 1'b0;
            if (pend_q.size() > 0) begin
                if (lat == 0) begin
                    logic [13:0] p;
                    p = pend_q.pop_front();
                    mem_rsp_valid = 1'b1;
                    mem_rsp_data  = {word_at({p, 1'b0}), word_at({p, 1'b1})};
                end else begin
                    lat--;
                end
            end
            #1;
            // R4: odd partner offered the cycle after an even acceptance
            if (prev_even_fire)
                check(ins_valid == 1'b1, "R4 buffered word next cycle", ins_valid, 1);
            // R5: held offer stays stable
            if (prev_hold) begin
                check(ins_valid && ins_word == hold_word && ins_pc == hold_pc,
                      "R5 offer held stable", {ins_pc, ins_word}, {hold_pc, hold_word});
            end
            // R6: after a branch the counter shows the target and nothing is offered
            if (redir_pending_chk) begin
                check(ins_pc == model_pc && !ins_valid, "R6 branch loads counter", ins_pc, model_pc);
                redir_pending_chk = 0;
            end
            fire_req = mem_req_valid && mem_req_ready;
            if (fire_req) begin
                check(pend_q.size() == 0, "R2 one outstanding request", pend_q.size(), 0);
                check(mem_req_addr == model_pc[14:1], first_req ? "R1 first request pair" : "R2 request pair address",
                      mem_req_addr, model_pc[14:1]);
                first_req = 0;
                pend_q.push_back(mem_req_addr);
                lat = $urandom % 3;
                reqs_since++;
            end
            fire_ins = ins_valid && ins_ready && !redir;
            prev_hold = ins_valid && !ins_ready && !redir;
            hold_word = ins_word;
            hold_pc   = ins_pc;
            if (ins_valid && ins_ready && redir) after_collide = 1; // R9 setup
            if (fire_ins) begin
                idle_cycles = 0;
                check(ins_pc == model_pc,
                      after_collide ? "R9 branch beats acceptance" : (after_wrap ? "R8 counter wraps" : "R5 counter sequence"),
                      ins_pc, model_pc);
                check(ins_word == word_at(model_pc), model_pc[0] ? "R3 odd word delivered" : "R3 even word delivered",
                      ins_word, word_at(model_pc));
                if (model_pc[0] && prev_even_pc == model_pc - 15'd1 && reqs_since == 0 && !after_collide)
                    check(1'b1, "R4 buffer hit without memory", reqs_since, 0);
                else if (model_pc[0] && !(prev_even_pc == model_pc - 15'd1))
                    check(reqs_since >= 1, "R7 odd target fetched from memory", reqs_since, 1);
                else if (!model_pc[0])
                    check(reqs_since >= 1, "R7 even word needs memory", reqs_since, 1);
                else
                    check(reqs_since == 0, "R4 no request for partner", reqs_since, 0);
                after_collide = 0;
                after_wrap = (model_pc == 15'h7FFF);
                prev_even_fire = !model_pc[0];
                prev_even_pc = model_pc[0] ? 15'h7FFF : model_pc;
                if (!model_pc[0]) reqs_since = 0;
                model_pc = model_pc + 15'd1;
            end else begin
                prev_even_fire = 0;
                idle_cycles++;
            end
            if (redir) begin
                // R6: stale buffer or responses must not be used after this point
                model_pc = redirect_pc;
                reqs_since = 0;
                prev_even_pc = 15'h7FFF;
                prev_even_fire = 0;
                prev_hold = 0;
                after_wrap = 0;
                redir_pending_chk = 1;
            end
            if (idle_cycles > 400) begin
                check(1'b0, "R5 watchdog no progress", idle_cycles, 0);
                break;
            end
        end
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        #1500000;
        n_cmp++;
        n_bad++;
        $display("FAIL R5 watchdog timeout: actual 1 expected 0");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule